// File: doc/BRIEF.md
# Data-Mode Drop-Lock Monitor

This block decides when a spread-spectrum receiver gives up on the packet it is demodulating and goes back to acquisition. While data mode is active, two per-symbol quality figures arrive with each symbol strobe: a bit-sync amplitude and a phase-error magnitude. The block sums each figure over non-overlapping windows of 128 symbols. At the end of each window it tests the two sums against their own data-mode thresholds. Lock is dropped when the amplitude sum is too low or when the phase-error sum is too high. These thresholds are separate from whatever the acquisition logic uses. An amplitude threshold of zero together with an all-ones phase threshold switches the quality test off, which leaves that decision to an external controller.

In parallel, a symbol-counted timer limits the search for the start-frame delimiter. The timer starts when data mode begins and stops for good when the delimiter-found pulse arrives. If the programmed number of symbols passes first, the block forces a return to acquisition.

Every drop appears as a one-cycle pulse together with a 2-bit cause code. A drop ends data mode. Data mode then stays off until the next data-start pulse, and that pulse restarts every counter and sum.

Top module: `dlock_monitor`

## Requirements
- R1: After reset `drop_pulse` is 0 and `drop_cause` is 00, and data mode is inactive.
- R2: A strobe is counted only while data mode is active. When the 128th counted strobe of a window arrives, the block sums the `amp_in` values of those 128 strobes. If that sum is strictly below `amp_thr`, `drop_pulse` is 1 in the cycle after that strobe, with `drop_cause` = 01.
- R3: At the same point, if the sum of the 128 `phs_in` values is strictly above `phs_thr`, the block drops with `drop_cause` = 10.
- R4: The thresholds are compared only at the end of each 128-symbol window. No quality drop occurs before 128 strobes have been counted. Both sums restart at zero for each new window.
- R5: Cause priority when conditions coincide: SFD timeout (11) first, then low amplitude (01), then high phase error (10).
- R6: With `amp_thr` = 0 and `phs_thr` all ones, no quality drop ever occurs, whatever the metric values.
- R7: Without a delimiter, the block drops with cause 11 on the N-th counted strobe after data start. N is `sfd_tmo`, and a value of 0 means 256.
- R8: A `sfd_found` pulse seen during data mode stops the timer for the rest of that data mode. This holds even when the pulse comes in the same cycle as the strobe that would have expired it.
- R9: A drop ends data mode, and later strobes have no effect until `data_start`. A `data_start` restarts the window, the sums and the timer. A strobe in the same cycle as `data_start` is not counted.
- R10: `drop_pulse` lasts exactly one cycle. `drop_cause` is 00 whenever `drop_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_start | input | 1 | Pulse: enter data mode and restart all counters |
| sym_stb | input | 1 | One-cycle strobe per received symbol |
| amp_in | input | AMP_W | Bit-sync amplitude of the current symbol |
| phs_in | input | PHS_W | Phase-error magnitude of the current symbol |
| sfd_found | input | 1 | Pulse: start-frame delimiter detected |
| amp_thr | input | AMP_W+WIN_LOG2 | Minimum acceptable amplitude sum per window |
| phs_thr | input | PHS_W+WIN_LOG2 | Maximum acceptable phase-error sum per window |
| sfd_tmo | input | TMO_W | Delimiter search limit in symbols (0 means 256) |
| drop_pulse | output | 1 | One-cycle request to return to acquisition |
| drop_cause | output | 2 | 01 low amplitude, 10 high phase error, 11 delimiter timeout, 00 idle |

## Verification
Several properties are checked on every cycle. The pulse is a single cycle wide, the cause is zero between pulses, and a quality-based drop never comes before a full window of strobes. A timeout is never reported once the delimiter has been seen, and the disabled-threshold setting yields timeout drops only. The bench scenarios cover the rest. They confirm the exact strobe on which each drop lands and the strict comparisons at the threshold boundaries. They also show that the sums restart per window, the priority order between causes, and that strobes are ignored outside data mode and in the data-start cycle.

// File: rtl/dlm_pkg.sv
package dlm_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_AMP  = 2'b01,
        CAUSE_PHS  = 2'b10,
        CAUSE_SFD  = 2'b11
    } drop_cause_e;

endpackage

// File: rtl/dlm_integrator.sv
module dlm_integrator #(
    parameter int IN_W  = 8,
    parameter int SUM_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             acc_en,
    input  logic [IN_W-1:0]  sample,
    output logic [SUM_W-1:0] sum_next
);

    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] sum_d;

    // Sum including the sample presented this cycle
    assign sum_next = sum_q + {{(SUM_W-IN_W){1'b0}}, sample};

    always_comb begin
        sum_d = sum_q;
        if (clr) begin
            sum_d = '0;
        end else if (acc_en) begin
            sum_d = sum_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

endmodule

// File: rtl/dlm_sfd_timer.sv
module dlm_sfd_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             tick,
    input  logic             kill,
    input  logic [TMO_W-1:0] tmo,
    output logic             expire
);

    localparam int CNT_W = TMO_W + 1;

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t             st_q, st_d;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        // A zero setting stands for the full 2**TMO_W symbols
        limit   = {(tmo == '0), tmo};
        cnt_inc = st_q.cnt + {{(CNT_W-1){1'b0}}, 1'b1};
        expire  = st_q.run && tick && !stop && (cnt_inc == limit);

        st_d = st_q;
        if (start) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
        end else if (kill || stop) begin
            st_d.run = 1'b0;
        end else if (tick && st_q.run) begin
            st_d.cnt = cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/dlock_monitor.sv
module dlock_monitor
    import dlm_pkg::*;
#(
    parameter int AMP_W    = 8,
    parameter int PHS_W    = 8,
    parameter int WIN_LOG2 = 7,
    parameter int TMO_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      data_start,
    input  logic                      sym_stb,
    input  logic [AMP_W-1:0]          amp_in,
    input  logic [PHS_W-1:0]          phs_in,
    input  logic                      sfd_found,
    input  logic [AMP_W+WIN_LOG2-1:0] amp_thr,
    input  logic [PHS_W+WIN_LOG2-1:0] phs_thr,
    input  logic [TMO_W-1:0]          sfd_tmo,
    output logic                      drop_pulse,
    output logic [1:0]                drop_cause
);

    localparam int AMP_SUM_W = AMP_W + WIN_LOG2;
    localparam int PHS_SUM_W = PHS_W + WIN_LOG2;
    localparam logic [WIN_LOG2-1:0] WIN_LAST = '1;
    localparam logic [WIN_LOG2-1:0] WIN_ONE  = {{(WIN_LOG2-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic                active;
        logic [WIN_LOG2-1:0] win;
        logic                pulse;
        drop_cause_e         cause;
    } mon_t;

    mon_t                 st_q, st_d;
    logic                 tick;
    logic                 win_end;
    logic                 amp_low;
    logic                 phs_high;
    logic                 tmo_hit;
    logic                 drop;
    logic                 sum_clr;
    logic [AMP_SUM_W-1:0] amp_sum;
    logic [PHS_SUM_W-1:0] phs_sum;

    dlm_integrator #(.IN_W(AMP_W), .SUM_W(AMP_SUM_W)) u_amp_int (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sum_clr),
        .acc_en   (tick),
        .sample   (amp_in),
        .sum_next (amp_sum)
    );

    dlm_integrator #(.IN_W(PHS_W), .SUM_W(PHS_SUM_W)) u_phs_int (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sum_clr),
        .acc_en   (tick),
        .sample   (phs_in),
        .sum_next (phs_sum)
    );

    dlm_sfd_timer #(.TMO_W(TMO_W)) u_sfd_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (data_start),
        .stop   (sfd_found),
        .tick   (tick),
        .kill   (drop),
        .tmo    (sfd_tmo),
        .expire (tmo_hit)
    );

    always_comb begin
        tick     = sym_stb && st_q.active && !data_start;
        win_end  = tick && (st_q.win == WIN_LAST);
        amp_low  = win_end && (amp_sum < amp_thr);
        phs_high = win_end && (phs_sum > phs_thr);
        drop     = tmo_hit || amp_low || phs_high;
        sum_clr  = data_start || drop || win_end;

        st_d       = st_q;
        st_d.pulse = drop;
        if (tmo_hit)       st_d.cause = CAUSE_SFD;
        else if (amp_low)  st_d.cause = CAUSE_AMP;
        else if (phs_high) st_d.cause = CAUSE_PHS;
        else               st_d.cause = CAUSE_NONE;

        if (data_start) begin
            st_d.active = 1'b1;
            st_d.win    = '0;
        end else if (drop) begin
            st_d.active = 1'b0;
            st_d.win    = '0;
        end else if (tick) begin
            st_d.win = st_q.win + WIN_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drop_pulse = st_q.pulse;
    assign drop_cause = st_q.cause;

endmodule

// File: rtl/dlm_checker.sv
module dlm_checker #(
    parameter int AMP_W    = 8,
    parameter int PHS_W    = 8,
    parameter int WIN_LOG2 = 7
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      data_start,
    input logic                      sym_stb,
    input logic                      sfd_found,
    input logic [AMP_W+WIN_LOG2-1:0] amp_thr,
    input logic [PHS_W+WIN_LOG2-1:0] phs_thr,
    input logic                      drop_pulse,
    input logic [1:0]                drop_cause
);

    // Strobes since the last data start, saturating at one full window
    logic [WIN_LOG2:0] sym_cnt_q;
    logic              sfd_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sym_cnt_q  <= '0;
            sfd_seen_q <= 1'b0;
        end else begin
            if (data_start) begin
                sym_cnt_q  <= '0;
                sfd_seen_q <= 1'b0;
            end else begin
                if (sym_stb && !sym_cnt_q[WIN_LOG2])
                    sym_cnt_q <= sym_cnt_q + 1'b1;
                if (sfd_found)
                    sfd_seen_q <= 1'b1;
            end
        end
    end

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |=> !drop_pulse);

    a_r10_idle_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !drop_pulse |-> (drop_cause == 2'b00));

    a_r4_full_window: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_pulse && drop_cause != 2'b11) |-> sym_cnt_q[WIN_LOG2]);

    a_r8_no_tmo_after_sfd: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_pulse && drop_cause == 2'b11) |-> !sfd_seen_q);

    a_r6_quality_off: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_pulse && $past(amp_thr) == '0 && $past(phs_thr) == '1)
            |-> (drop_cause == 2'b11));

endmodule

bind dlock_monitor dlm_checker #(
    .AMP_W    (AMP_W),
    .PHS_W    (PHS_W),
    .WIN_LOG2 (WIN_LOG2)
) u_dlm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_start (data_start),
    .sym_stb    (sym_stb),
    .sfd_found  (sfd_found),
    .amp_thr    (amp_thr),
    .phs_thr    (phs_thr),
    .drop_pulse (drop_pulse),
    .drop_cause (drop_cause)
);

// File: tb/dlock_monitor_bench.sv
module dlock_monitor_bench;

    localparam int SW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          data_start = 1'b0;
    logic          sym_stb = 1'b0;
    logic [7:0]    amp_in = '0;
    logic [7:0]    phs_in = '0;
    logic          sfd_found = 1'b0;
    logic [SW-1:0] amp_thr = '0;
    logic [SW-1:0] phs_thr = '1;
    logic [7:0]    sfd_tmo = '0;
    logic          drop_pulse;
    logic [1:0]    drop_cause;

    int   n_checks = 0;
    int   n_fail = 0;
    logic got_p;
    logic [1:0] got_c;

    always #2 clk = ~clk;

    dlock_monitor u_dlock_monitor (
        .clk(clk), .rst_n(rst_n), .data_start(data_start), .sym_stb(sym_stb),
        .amp_in(amp_in), .phs_in(phs_in), .sfd_found(sfd_found),
        .amp_thr(amp_thr), .phs_thr(phs_thr), .sfd_tmo(sfd_tmo),
        .drop_pulse(drop_pulse), .drop_cause(drop_cause)
    );

    task automatic sample_out();
        got_p = drop_pulse;
        got_c = drop_cause;
    endtask

    task automatic chk(input string tag, input logic ep, input logic [1:0] ec);
        n_checks++;
        if (got_p !== ep || got_c !== ec) begin
            n_fail++;
            $display("FAIL %s: pulse=%0b cause=%b expected pulse=%0b cause=%b",
                     tag, got_p, got_c, ep, ec);
        end
    endtask

    task automatic send_sym(input int a, input int p, input logic sfd);
        sym_stb   = 1'b1;
        amp_in    = a[7:0];
        phs_in    = p[7:0];
        sfd_found = sfd;
        @(negedge clk);
        sym_stb   = 1'b0;
        sfd_found = 1'b0;
        sample_out();
    endtask

    task automatic start_data();
        data_start = 1'b1;
        @(negedge clk);
        data_start = 1'b0;
        sample_out();
    endtask

    // One window of constant metrics; timer stopped by an early delimiter
    task automatic quality_case(input string tag, input int a, input int p,
                                input int athr, input int pthr, input logic [1:0] ec);
        amp_thr = athr[SW-1:0];
        phs_thr = pthr[SW-1:0];
        sfd_tmo = 8'd0;
        start_data();
        for (int i = 1; i <= 128; i++) begin
            send_sym(a, p, i == 1);
            if (i < 128) chk({tag, " early"}, 1'b0, 2'b00);
            else         chk(tag, ec != 2'b00, ec);
        end
        @(negedge clk);
    endtask

    task automatic tmo_case(input string tag, input int tmo, input int athr,
                            input int a, input logic [1:0] ec, input int at);
        amp_thr = athr[SW-1:0];
        phs_thr = '1;
        sfd_tmo = tmo[7:0];
        start_data();
        for (int i = 1; i <= at; i++) begin
            send_sym(a, 0, 1'b0);
            if (i < at) chk({tag, " early"}, 1'b0, 2'b00);
            else        chk(tag, 1'b1, ec);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int alist[5] = '{0, 1, 2, 77, 255};
        int ramp_sum;
        repeat (3) @(negedge clk);
        sample_out();
        chk("R1 reset", 1'b0, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        sample_out();
        chk("R1 after release", 1'b0, 2'b00);

        // R2: amplitude threshold boundary sweep (drop iff 128*a < thr)
        foreach (alist[k]) begin
            for (int d = -1; d <= 1; d++) begin
                int thr = 128 * alist[k] + d;
                if (thr >= 0)
                    quality_case("R2 amp sweep", alist[k], 0, thr, 32767,
                                 (128 * alist[k] < thr) ? 2'b01 : 2'b00);
            end
        end

        // R3: phase threshold boundary sweep (drop iff 128*p > thr)
        foreach (alist[k]) begin
            for (int d = -1; d <= 1; d++) begin
                int thr = 128 * alist[k] + d;
                if (thr >= 0)
                    quality_case("R3 phase sweep", 0, alist[k], 0, thr,
                                 (128 * alist[k] > thr) ? 2'b10 : 2'b00);
            end
        end

        // R2: varying amplitudes, sum computed here
        ramp_sum = 0;
        for (int i = 0; i < 128; i++) ramp_sum += (i * 13) % 200;
        for (int d = 0; d <= 1; d++) begin
            amp_thr = SW'(ramp_sum + d);
            phs_thr = '1;
            sfd_tmo = 8'd0;
            start_data();
            for (int i = 0; i < 128; i++) begin
                send_sym((i * 13) % 200, 3, i == 0);
                if (i < 127) chk("R2 ramp early", 1'b0, 2'b00);
                else         chk("R2 ramp", d == 1, (d == 1) ? 2'b01 : 2'b00);
            end
            @(negedge clk);
        end

        // R5: both quality conditions -> amplitude wins
        quality_case("R5 amp over phase", 10, 10, 2000, 100, 2'b01);
        // R6: disabled thresholds with worst metrics
        quality_case("R6 disabled", 0, 255, 0, 32767, 2'b00);

        // R4: sums restart per window; second window fails alone
        amp_thr = SW'(6400);
        phs_thr = '1;
        sfd_tmo = 8'd0;
        start_data();
        for (int i = 1; i <= 256; i++) begin
            send_sym((i <= 128) ? 100 : 49, 0, i == 1);
            if (i < 256) chk("R4 no drop before window end", 1'b0, 2'b00);
            else         chk("R4 second window", 1'b1, 2'b01);
        end
        @(negedge clk);

        // R7: timeout sweep, quality test disabled
        tmo_case("R7 tmo=1", 1, 0, 5, 2'b11, 1);
        tmo_case("R7 tmo=2", 2, 0, 5, 2'b11, 2);
        tmo_case("R7 tmo=3", 3, 0, 5, 2'b11, 3);
        tmo_case("R7 tmo=37", 37, 0, 5, 2'b11, 37);
        tmo_case("R7 tmo=200", 200, 0, 5, 2'b11, 200);
        tmo_case("R7 tmo=0 means 256", 0, 0, 5, 2'b11, 256);
        // R5: timeout on the window's last symbol beats low amplitude
        tmo_case("R5 tmo over amp", 128, 30000, 0, 2'b11, 128);
        // R5/R2: quality drop comes first when timeout is later
        tmo_case("R5 amp before tmo", 200, 30000, 0, 2'b01, 128);

        // R8: delimiter on the expiring strobe cancels the timeout
        amp_thr = '0;
        phs_thr = '1;
        sfd_tmo = 8'd5;
        start_data();
        for (int i = 1; i <= 20; i++) begin
            send_sym(1, 1, i == 5);
            chk("R8 sfd on expiry strobe", 1'b0, 2'b00);
        end
        // R8: delimiter between strobes
        sfd_tmo = 8'd3;
        start_data();
        send_sym(1, 1, 1'b0);
        sfd_found = 1'b1;
        @(negedge clk);
        sfd_found = 1'b0;
        for (int i = 1; i <= 10; i++) begin
            send_sym(1, 1, 1'b0);
            chk("R8 sfd between strobes", 1'b0, 2'b00);
        end

        // R9: after a drop, strobes have no effect
        tmo_case("R9 setup drop", 1, 0, 5, 2'b11, 1);
        amp_thr = '1;
        for (int i = 1; i <= 300; i++) begin
            send_sym(0, 255, 1'b0);
            chk("R9 inactive ignores strobes", 1'b0, 2'b00);
        end
        // R9: strobe in the data_start cycle is not counted
        amp_thr    = '0;
        sfd_tmo    = 8'd1;
        data_start = 1'b1;
        sym_stb    = 1'b1;
        @(negedge clk);
        data_start = 1'b0;
        sym_stb    = 1'b0;
        sample_out();
        chk("R9 start-cycle strobe ignored", 1'b0, 2'b00);
        @(negedge clk);
        sample_out();
        chk("R9 start-cycle strobe ignored", 1'b0, 2'b00);
        send_sym(0, 0, 1'b0);
        chk("R9 first counted strobe", 1'b1, 2'b11);
        @(negedge clk);
        sample_out();
        chk("R10 pulse one cycle", 1'b0, 2'b00);

        // R9: restart mid-window
        amp_thr = '1;
        phs_thr = '1;
        sfd_tmo = 8'd0;
        start_data();
        for (int i = 1; i <= 100; i++) begin
            send_sym(0, 0, i == 1);
            chk("R9 before restart", 1'b0, 2'b00);
        end
        start_data();
        for (int i = 1; i <= 128; i++) begin
            send_sym(0, 0, i == 1);
            if (i < 128) chk("R9 restarted window", 1'b0, 2'b00);
            else         chk("R9 restarted window end", 1'b1, 2'b01);
        end
        @(negedge clk);
        sample_out();
        chk("R10 idle cause", 1'b0, 2'b00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule